// File: doc/BRIEF.md
# Serial Bus Shift Unit with Programmable Bit Count

This block moves one data unit between a parallel register and the serial data line of a two-wire bus, paced by clock edges that another block generates. Software loads the register, chooses how many bits the next unit carries through a 3-bit count field, and picks whether a ninth acknowledge clock follows and what level the unit drives during it. Transmit data leave most significant bit first. Received bits enter at bit 0 as the register moves left. The block raises a one-cycle interrupt when the unit is complete.

A START strobe from a separate condition detector forces the count field back to zero, which selects eight bits, so an address unit always has full width. START also marks the bus busy, and STOP clears that mark. In master mode the block compares the level it leaves on the line with the level it samples, and flags lost arbitration when they differ. Clearing the enable input releases the line, forces the status outputs to fixed values and blocks register writes. The data line is open-drain, so the block only ever pulls it low. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `i2c_shift_unit`

## Requirements
- R1: The count field sets the bits per unit. A value n from 1 to 7 transfers n bits, and 000 transfers 8. The field is loaded from `cnt_i` when `cnt_wr_i` is high.
- R2: A `start_i` pulse clears the count field to 000 and sets `busy_o`. A later `stop_i` pulse clears `busy_o`. START takes priority over STOP.
- R3: During the data phase, `sda_oe_o` is 1 (pull low) exactly when bit 7 of the register is 0. On each SCL falling edge, the register shifts left by one and takes the bit sampled at the preceding SCL rising edge into bit 0.
- R4: With `ack_clk_i`=1, one extra clock follows the data bits. During that clock `sda_oe_o` equals the inverse of `ack_val_i` (0 = acknowledge by pulling low, 1 = release).
- R5: `irq_o` is a one-cycle pulse in the clock cycle after the SCL falling edge that ends the unit. That edge ends the acknowledge clock when one is enabled, and the last data bit otherwise. `no_req_o` drops to 0 in the same cycle.
- R6: A write (`wr_i`) while enabled loads `wdata_i`, sets `no_req_o` to 1 and restarts the bit count.
- R7: While `en_i`=0, `sda_oe_o` is 0, the status outputs read `no_req_o`=1, `busy_o`=0 and `arb_lost_o`=0, and SCL edges have no effect.
- R8: A write while `en_i`=0 leaves `rdata_o` unchanged.
- R9: With `mst_i`=1, if bit 7 is 1 (line released) and SDA is sampled 0 at an SCL rise, `arb_lost_o` becomes 1. The line then stays released until the next START clears the flag.
- R10: After reset, `rdata_o`=0, `no_req_o`=1, and `busy_o`, `arb_lost_o`, `irq_o` and `sda_oe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Unit enable |
| scl_i | input | 1 | Serial clock line level, synchronous to clk |
| sda_i | input | 1 | Serial data line level, synchronous to clk |
| start_i | input | 1 | START condition strobe |
| stop_i | input | 1 | STOP condition strobe |
| wr_i | input | 1 | Data register write strobe |
| wdata_i | input | DW | Data register write value |
| cnt_wr_i | input | 1 | Count field write strobe |
| cnt_i | input | CW | Count field write value |
| ack_clk_i | input | 1 | Enable the acknowledge clock |
| ack_val_i | input | 1 | Acknowledge level: 0 pull low, 1 release |
| mst_i | input | 1 | Master transmitter mode, enables the arbitration check |
| sda_oe_o | output | 1 | Pull the data line low |
| rdata_o | output | DW | Data register value |
| irq_o | output | 1 | Unit-complete interrupt pulse |
| no_req_o | output | 1 | 1 when no completion is waiting for service |
| busy_o | output | 1 | Bus busy flag |
| arb_lost_o | output | 1 | Arbitration lost flag |

## Verification
The hardest situation to reach is a count field that software set to a short value and that START then silently overrode. It shows only in the pulse on which the interrupt appears, not on any output level. The stimulus loads a count of five, issues START, runs eight clocks, and checks the interrupt count after every single pulse. Lost arbitration is reached the same way through the ports: in master mode the bench releases a 1 onto a bus that its own model of another driver holds low. It then checks that a later 0 in the register no longer pulls the line.

// File: rtl/isu_pkg.sv
package isu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;
endpackage

// File: rtl/isu_edge.sv
// Serial clock edge detector: one registered copy of SCL, edges gated by enable.
module isu_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl,
  output logic rise,
  output logic fall
);
  logic scl_q, scl_d;

  always_comb begin
    scl_d = scl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_d;
  end

  assign rise = en &  scl & ~scl_q;
  assign fall = en & ~scl &  scl_q;
endmodule

// File: rtl/isu_seq.sv
// Bit sequencer: count field, bits-done counter, phase and interrupt.
module isu_seq
  import isu_pkg::*;
#(
  parameter  int unsigned DW  = 8,
  localparam int unsigned CW  = $clog2(DW),
  localparam int unsigned DNW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rise,
  input  logic          fall,
  input  logic          start,
  input  logic          stop,
  input  logic          load,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_in,
  input  logic          ack_clk,
  output phase_t        phase,
  output logic          irq_set,
  output logic          irq
);
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [DNW-1:0] done_q, done_d, nbits;
  phase_t         ph_q, ph_d;
  logic           irq_q;

  assign nbits = (cnt_q == '0) ? DNW'(DW) : {1'b0, cnt_q};

  always_comb begin
    cnt_d   = cnt_q;
    done_d  = done_q;
    ph_d    = ph_q;
    irq_set = 1'b0;
    if (cnt_wr) cnt_d = cnt_in;
    if (!en) begin
      ph_d   = PH_IDLE;
      done_d = '0;
    end else if (start || load) begin
      ph_d   = PH_DATA;
      done_d = '0;
      if (start) cnt_d = '0;
    end else if (stop) begin
      ph_d   = PH_IDLE;
      done_d = '0;
    end else begin
      unique case (ph_q)
        PH_DATA: begin
          if (rise) begin
            done_d = done_q + DNW'(1);
          end else if (fall && done_q == nbits) begin
            if (ack_clk) begin
              ph_d = PH_ACK;
            end else begin
              ph_d    = PH_IDLE;
              irq_set = 1'b1;
            end
          end
        end
        PH_ACK: begin
          if (rise) begin
            done_d = done_q + DNW'(1);
          end else if (fall && done_q == nbits + DNW'(1)) begin
            ph_d    = PH_IDLE;
            irq_set = 1'b1;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= '0;
      ph_q   <= PH_IDLE;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ph_q   <= ph_d;
      irq_q  <= irq_set;
    end
  end

  assign phase = ph_q;
  assign irq   = irq_q;
endmodule

// File: rtl/isu_shift.sv
// Data register: sample on SCL rise, shift left on SCL fall.
module isu_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          restart,
  input  logic [DW-1:0] wdata,
  input  logic          d_rise,
  input  logic          d_fall,
  input  logic          sda,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_q, q_d;
  logic          samp_q, samp_d;
  logic          sv_q, sv_d;

  always_comb begin
    q_d    = q_q;
    samp_d = samp_q;
    sv_d   = sv_q;
    if (!en) begin
      sv_d = 1'b0;
    end else if (load || restart) begin
      if (load) q_d = wdata;
      sv_d = 1'b0;
    end else if (d_rise) begin
      samp_d = sda;
      sv_d   = 1'b1;
    end else if (d_fall && sv_q) begin
      q_d  = {q_q[DW-2:0], samp_q};
      sv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      samp_q <= 1'b0;
      sv_q   <= 1'b0;
    end else begin
      q_q    <= q_d;
      samp_q <= samp_d;
      sv_q   <= sv_d;
    end
  end

  assign q = q_q;
endmodule

// File: rtl/i2c_shift_unit.sv
module i2c_shift_unit
  import isu_pkg::*;
#(
  parameter  int unsigned DW          = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW          = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ack_clk_i,
  input  logic          ack_val_i,
  input  logic          mst_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          no_req_o,
  output logic          busy_o,
  output logic          arb_lost_o
);
  // Reset synchronizer: asynchronous assert, synchronous release.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_rsync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end
  assign rst_q = sync_q[SYNC_STAGES-1];

  logic          rise, fall, d_rise, d_fall, load;
  logic          irq_set;
  phase_t        phase;
  logic [DW-1:0] q;

  isu_edge u_edge (
    .clk  (clk),
    .rst_n(rst_q),
    .en   (en_i),
    .scl  (scl_i),
    .rise (rise),
    .fall (fall)
  );

  assign load   = en_i & wr_i;
  assign d_rise = rise & (phase == PH_DATA);
  assign d_fall = fall & (phase == PH_DATA);

  isu_seq #(.DW(DW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_q),
    .en     (en_i),
    .rise   (rise),
    .fall   (fall),
    .start  (start_i),
    .stop   (stop_i),
    .load   (load),
    .cnt_wr (cnt_wr_i),
    .cnt_in (cnt_i),
    .ack_clk(ack_clk_i),
    .phase  (phase),
    .irq_set(irq_set),
    .irq    (irq_o)
  );

  isu_shift #(.DW(DW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_q),
    .en     (en_i),
    .load   (load),
    .restart(start_i),
    .wdata  (wdata_i),
    .d_rise (d_rise),
    .d_fall (d_fall),
    .sda    (sda_i),
    .q      (q)
  );

  // Status flags
  logic busy_q, busy_d, al_q, al_d, nrq_q, nrq_d;

  always_comb begin
    busy_d = busy_q;
    al_d   = al_q;
    nrq_d  = nrq_q;
    if (!en_i) begin
      busy_d = 1'b0;
      al_d   = 1'b0;
      nrq_d  = 1'b1;
    end else begin
      if (start_i)     busy_d = 1'b1;
      else if (stop_i) busy_d = 1'b0;
      if (start_i)
        al_d = 1'b0;
      else if (d_rise && mst_i && q[DW-1] && !sda_i)
        al_d = 1'b1;
      if (load)         nrq_d = 1'b1;
      else if (irq_set) nrq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      busy_q <= 1'b0;
      al_q   <= 1'b0;
      nrq_q  <= 1'b1;
    end else begin
      busy_q <= busy_d;
      al_q   <= al_d;
      nrq_q  <= nrq_d;
    end
  end

  assign sda_oe_o   = en_i & ~al_q &
                      (((phase == PH_DATA) & ~q[DW-1]) |
                       ((phase == PH_ACK)  & ~ack_val_i));
  assign rdata_o    = q;
  assign busy_o     = busy_q;
  assign arb_lost_o = al_q;
  assign no_req_o   = nrq_q;
endmodule

// File: rtl/isu_chk.sv
module isu_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic          wr_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          sda_oe_o,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic          no_req_o,
  input logic          busy_o,
  input logic          arb_lost_o
);
  AST_DIS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (no_req_o && !busy_o && !arb_lost_o)); // R7
  AST_DIS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !sda_oe_o); // R7
  AST_DIS_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && wr_i) |=> $stable(rdata_o)); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R5
  AST_IRQ_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !no_req_o); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && start_i) |=> busy_o); // R2
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && stop_i && !start_i) |=> !busy_o); // R2
  AST_AL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |-> !sda_oe_o); // R9
endmodule

bind i2c_shift_unit isu_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .en_i      (en_i),
  .wr_i      (wr_i),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .sda_oe_o  (sda_oe_o),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .no_req_o  (no_req_o),
  .busy_o    (busy_o),
  .arb_lost_o(arb_lost_o)
);

// File: tb/tb_i2c_shift_unit.sv
`timescale 1ns/1ps
module tb_i2c_shift_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_i, scl_i, start_i, stop_i, wr_i, cnt_wr_i;
  logic       ack_clk_i, ack_val_i, mst_i, ext_sda;
  logic [7:0] wdata_i;
  logic [2:0] cnt_i;
  logic       sda_i, sda_oe_o, irq_o, no_req_o, busy_o, arb_lost_o;
  logic [7:0] rdata_o;

  int vectors = 0, fails = 0, irq_cnt = 0;

  always #2 clk = ~clk;

  // Open-drain bus: the other party drives ext_sda, the unit pulls low.
  assign sda_i = ext_sda & ~sda_oe_o;

  i2c_shift_unit dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .scl_i(scl_i), .sda_i(sda_i),
    .start_i(start_i), .stop_i(stop_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .cnt_wr_i(cnt_wr_i), .cnt_i(cnt_i), .ack_clk_i(ack_clk_i),
    .ack_val_i(ack_val_i), .mst_i(mst_i), .sda_oe_o(sda_oe_o),
    .rdata_o(rdata_o), .irq_o(irq_o), .no_req_o(no_req_o),
    .busy_o(busy_o), .arb_lost_o(arb_lost_o)
  );

  // ---------------- behavioural reference model ----------------
  int         m_sync, m_ph, m_done, m_cnt;
  bit         m_sclp, m_irq, m_nrq, m_busy, m_al;
  logic [7:0] m_q;
  bit         m_samp[$];

  task automatic model_step();
    bit rise, fall;
    int nb;
    if (!rst_n) m_sync = 0;
    if (!rst_n || m_sync < 2) begin
      if (rst_n) m_sync++;
      m_sclp = 1; m_ph = 0; m_done = 0; m_cnt = 0; m_q = 8'h00;
      m_irq = 0; m_nrq = 1; m_busy = 0; m_al = 0; m_samp.delete();
      return;
    end
    rise = en_i && scl_i && !m_sclp;
    fall = en_i && !scl_i && m_sclp;
    m_sclp = scl_i;
    nb = (m_cnt == 0) ? 8 : m_cnt;
    m_irq = 0;
    if (cnt_wr_i) m_cnt = cnt_i;
    if (!en_i) begin
      m_ph = 0; m_done = 0; m_samp.delete();
      m_nrq = 1; m_busy = 0; m_al = 0;
      return;
    end
    if (start_i) m_al = 0;
    else if (m_ph == 1 && rise && mst_i && m_q[7] && !sda_i) m_al = 1;
    if (start_i) m_busy = 1;
    else if (stop_i) m_busy = 0;
    if (start_i || wr_i) begin
      if (wr_i) begin m_q = wdata_i; m_nrq = 1; end
      if (start_i) m_cnt = 0;
      m_ph = 1; m_done = 0; m_samp.delete();
      return;
    end
    if (m_ph == 1) begin
      if (rise) m_samp.push_back(sda_i);
      else if (fall && m_samp.size() > 0) m_q = {m_q[6:0], m_samp.pop_front()};
    end
    if (stop_i) begin m_ph = 0; m_done = 0; return; end
    if (m_ph == 1) begin
      if (rise) m_done++;
      else if (fall && m_done == nb) begin
        if (ack_clk_i) m_ph = 2;
        else begin m_ph = 0; m_irq = 1; end
      end
    end else if (m_ph == 2) begin
      if (rise) m_done++;
      else if (fall && m_done == nb + 1) begin m_ph = 0; m_irq = 1; end
    end
    if (m_irq) m_nrq = 0;
  endtask

  task automatic cmp(string req, string sig, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, sig, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    cmp("R3", "sda_oe", sda_oe_o,
        en_i && !m_al && ((m_ph == 1 && !m_q[7]) || (m_ph == 2 && !ack_val_i)));
    cmp("R3", "rdata", rdata_o, m_q);
    cmp("R5", "irq", irq_o, m_irq);
    cmp("R5", "no_req", no_req_o, m_nrq);
    cmp("R2", "busy", busy_o, m_busy);
    cmp("R9", "arb_lost", arb_lost_o, m_al);
    if (irq_o) irq_cnt++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask

  task automatic write_data(input logic [7:0] v);
    @(negedge clk) begin wdata_i = v; wr_i = 1; end
    @(negedge clk) wr_i = 0;
  endtask

  task automatic write_cnt(input logic [2:0] v);
    @(negedge clk) begin cnt_i = v; cnt_wr_i = 1; end
    @(negedge clk) cnt_wr_i = 0;
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    @(negedge clk) begin ext_sda = b; scl_i = 0; end
    repeat (2) @(negedge clk);
    scl_i = 1;
    @(negedge clk) seen = sda_i;
    @(negedge clk) scl_i = 0;
    repeat (2) @(negedge clk);
  endtask

  // Runs npulse clocks (bits[npulse-1] first), checks the irq count after each.
  task automatic run_unit(string req, input int npulse, input int irq_at,
                          input logic [15:0] bits, output logic [15:0] obs);
    int base;
    logic s;
    base = irq_cnt;
    obs = '0;
    for (int k = 0; k < npulse; k++) begin
      clock_bit(bits[npulse-1-k], s);
      obs[npulse-1-k] = s;
      cmp(req, "irq count", irq_cnt - base, (k + 1 >= irq_at) ? 1 : 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [15:0] obs;
    int base;
    logic s;
    rst_n = 0; en_i = 0; scl_i = 1; ext_sda = 1; start_i = 0; stop_i = 0;
    wr_i = 0; wdata_i = 8'h00; cnt_wr_i = 0; cnt_i = 3'd0;
    ack_clk_i = 0; ack_val_i = 1; mst_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10: reset values
    cmp("R10", "rdata", rdata_o, 0);
    cmp("R10", "no_req", no_req_o, 1);
    cmp("R10", "busy", busy_o, 0);
    cmp("R10", "arb_lost", arb_lost_o, 0);
    cmp("R10", "irq", irq_o, 0);
    cmp("R10", "sda_oe", sda_oe_o, 0);

    en_i = 1;
    // R2, R3, R4, R6: master transmit of A5 with acknowledge from the other side
    pulse_start();
    cmp("R2", "busy after start", busy_o, 1);
    mst_i = 1; ack_clk_i = 1; ack_val_i = 1;
    write_data(8'hA5);
    cmp("R6", "no_req after write", no_req_o, 1);
    run_unit("R5", 9, 9, {8'hFF, 1'b0}, obs);
    cmp("R3", "bus bits msb first", obs[8:1], 8'hA5);
    cmp("R5", "no_req after irq", no_req_o, 0);

    // R1: count 3, receive 1,0,1 without acknowledge clock
    mst_i = 0; ack_clk_i = 0;
    write_cnt(3'd3);
    write_data(8'hFF);
    cmp("R6", "no_req restored", no_req_o, 1);
    run_unit("R1", 3, 3, 16'b101, obs);
    cmp("R1", "rdata 3-bit receive", rdata_o, 8'hFD);

    // R1: count 000 means eight bits
    write_cnt(3'd0);
    write_data(8'hFF);
    run_unit("R1", 8, 8, 16'h003C, obs);
    cmp("R1", "rdata 8-bit receive", rdata_o, 8'h3C);

    // R4: acknowledge clock with acknowledge low
    ack_clk_i = 1; ack_val_i = 0;
    write_cnt(3'd2);
    write_data(8'hFF);
    base = irq_cnt;
    clock_bit(1'b1, s);
    clock_bit(1'b1, s);
    cmp("R4", "ack drive low", sda_oe_o, 1);
    cmp("R4", "no irq before ack clock", irq_cnt - base, 0);
    clock_bit(1'b1, s);
    cmp("R4", "irq after ack clock", irq_cnt - base, 1);
    cmp("R4", "line released after ack", sda_oe_o, 0);

    // R2: START overrides a short count field
    ack_clk_i = 0; ack_val_i = 1;
    write_cnt(3'd5);
    pulse_start();
    write_data(8'hFF);
    run_unit("R2", 8, 8, 16'h005A, obs);
    cmp("R2", "rdata after forced 8", rdata_o, 8'h5A);

    // R9: arbitration lost
    pulse_start();
    mst_i = 1;
    write_data(8'hC0);
    clock_bit(1'b0, s);
    cmp("R9", "arb_lost set", arb_lost_o, 1);
    clock_bit(1'b0, s);
    cmp("R9", "released after loss", sda_oe_o, 0);
    pulse_start();
    cmp("R9", "start clears arb_lost", arb_lost_o, 0);
    pulse_stop();
    cmp("R2", "stop clears busy", busy_o, 0);

    // R7, R8: disable
    pulse_start();
    mst_i = 0;
    write_data(8'h12);
    @(negedge clk) en_i = 0;
    repeat (2) @(negedge clk);
    cmp("R7", "no_req forced", no_req_o, 1);
    cmp("R7", "busy forced", busy_o, 0);
    cmp("R7", "arb_lost forced", arb_lost_o, 0);
    cmp("R7", "line released", sda_oe_o, 0);
    write_data(8'h77);
    cmp("R8", "write ignored", rdata_o, 8'h12);
    base = irq_cnt;
    for (int k = 0; k < 9; k++) clock_bit(1'b0, s);
    cmp("R7", "edges ignored rdata", rdata_o, 8'h12);
    cmp("R7", "edges ignored irq", irq_cnt - base, 0);
    @(negedge clk) en_i = 1;
    repeat (2) @(negedge clk);
    cmp("R8", "rdata after re-enable", rdata_o, 8'h12);

    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule